// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches an asynchronous hot-plug-detect line from a display connector and turns it into clean connection events. The line is brought into the clock domain by a two-stage synchronizer. A debounce filter then passes a new level through only after the line has held that level for a programmable number of sample ticks. The spacing of those ticks is set by a power-of-two prescaler. Each change of the filtered level raises either a rise event or a fall event.

A level interrupt from an attached transmitter controller core is merged into the same status register. Status bits are sticky. Software clears them by writing ones to a clear register, normally by writing back the value it just read. An enable register, where a one lets the source through, gates the status bits into one registered interrupt output. A small register port with address, write strobe, write data and registered read data gives access to the filter setting, the status, the enables and the current filtered level.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset, status reads 0, enable reads 0, the filtered level reads 0, irq_o is 0, and the filter register (address 0) reads 0x0000A0A0.
- R2: The filtered level, read at address 4 bit 0, takes a new synchronized input value only after that value has held for LIMIT consecutive sample ticks. LIMIT is filter bits 11:0, and 0 counts as 1. A shorter pulse leaves the level unchanged.
- R3: One sample tick occurs every 2^EXP clock cycles, where EXP is filter bits 15:12. The same pulse that passes with EXP=0 is rejected with a larger EXP.
- R4: A 0-to-1 change of the filtered level sets status bit 1, and a 1-to-0 change sets status bit 2. A rejected glitch sets neither bit.
- R5: Status bit 0 is set in every cycle in which core_irq_i is high, and it stays set after core_irq_i falls.
- R6: Writing a pattern to the clear register (address 2) clears exactly the status bits that are one in the pattern. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: irq_o is the registered OR of (status AND enable), with enable held at address 3 bits 2:0. An all-zero enable keeps irq_o low.
- R8: A write to the status address (1) has no effect on the status bits.
- R9: The filter register holds bits 15:0 of a write and reads 0 in bits 31:16. Reads of the clear register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_async_i | input | 1 | Raw hot-plug-detect line, asynchronous |
| core_irq_i | input | 1 | Level interrupt from the controller core |
| reg_addr_i | input | ADDR_W (3) | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data, one cycle after the address |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The debounce path is driven with three input patterns. A two-cycle glitch at EXP=0 and LIMIT=4 must be rejected. A long hold must pass and raise exactly one edge event. An eight-cycle pulse with EXP=2 must be rejected, even though the same pulse would pass at EXP=0, which shows that the prescaler really stretches the window. The core interrupt is held high across a clear so that set-over-clear priority can be seen. The enable register is swept through a non-matching value and then a matching one, which shows that gating works per bit and is not an OR of all enables.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int ST_W = 3;
  localparam int ST_CORE = 0;
  localparam int ST_RISE = 1;
  localparam int ST_FALL = 2;
  localparam logic [2:0] A_FILTER = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_CLEAR  = 3'd2;
  localparam logic [2:0] A_ENABLE = 3'd3;
  localparam logic [2:0] A_LEVEL  = 3'd4;
  localparam logic [15:0] FILTER_RESET = 16'hA0A0;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce #(
  parameter int EXP_W = 4,
  parameter int CNT_W = 12,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PRE_W-1:0] pre_q, period_m1;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit_eff, cnt_next;
  logic             level_q, level_d1;

  assign period_m1 = ({{(PRE_W-1){1'b0}}, 1'b1} << exp_i) - 1'b1;
  assign tick      = (pre_q >= period_m1);
  assign limit_eff = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};
  assign cnt_next  = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || tick) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sync_i == level_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_next >= limit_eff) begin
        level_q <= sync_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_next[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d1 <= 1'b0;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
    end else begin
      level_d1 <= level_q;
      rise_o   <= level_q & ~level_d1;
      fall_o   <= ~level_q & level_d1;
    end
  end

  assign level_o = level_q;

  // R2: the level moves only toward the synchronized input, and only on a tick
  p_level_follows_sync_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> ($past(sync_i) == level_q) && $past(tick));
  // R2: the stability counter never passes the limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt_q} < limit_eff || $past(limit_i) != limit_i);
  // R4: a rise and a fall never come out together
  p_edge_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/hpd_regs.sv
module hpd_regs
  import hpd_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              core_irq_i,
  input  logic              level_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              irq_o
);
  localparam int FILT_W = EXP_W + CNT_W;

  logic [FILT_W-1:0] filter_q;
  logic [ST_W-1:0]   status_q, enable_q, set_vec, clr_vec;
  logic              wr_filter, wr_clear, wr_enable;

  assign wr_filter = we_i && (addr_i == ADDR_W'(A_FILTER));
  assign wr_clear  = we_i && (addr_i == ADDR_W'(A_CLEAR));
  assign wr_enable = we_i && (addr_i == ADDR_W'(A_ENABLE));

  assign set_vec = {fall_i, rise_i, core_irq_i};
  assign clr_vec = wr_clear ? wdata_i[ST_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      filter_q <= FILT_W'(FILTER_RESET);
      enable_q <= '0;
    end else begin
      if (wr_filter) filter_q <= wdata_i[FILT_W-1:0];
      if (wr_enable) enable_q <= wdata_i[ST_W-1:0];
    end
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_status
    always_ff @(posedge clk) begin
      if (rst)             status_q[i] <= 1'b0;
      else if (set_vec[i]) status_q[i] <= 1'b1;
      else if (clr_vec[i]) status_q[i] <= 1'b0;
    end
    // R6: a set bit survives unless a clear for it is written
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      status_q[i] && !(wr_clear && wdata_i[i]) |=> status_q[i]);
    // R6: a set event in the clear cycle leaves the bit set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> status_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_q & enable_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      rdata_o <= '0;
      case (addr_i)
        ADDR_W'(A_FILTER): rdata_o[FILT_W-1:0] <= filter_q;
        ADDR_W'(A_STATUS): rdata_o[ST_W-1:0]   <= status_q;
        ADDR_W'(A_ENABLE): rdata_o[ST_W-1:0]   <= enable_q;
        ADDR_W'(A_LEVEL):  rdata_o[0]          <= level_i;
        default:           rdata_o             <= '0;
      endcase
    end
  end

  assign exp_o   = filter_q[FILT_W-1:CNT_W];
  assign limit_o = filter_q[CNT_W-1:0];

  // R7: the interrupt needs a nonzero enable one cycle earlier
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(enable_q) != '0);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 12,
  parameter int PRE_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hpd_async_i,
  input  logic              core_irq_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic             hpd_sync, level, rise, fall;
  logic [EXP_W-1:0] filt_exp;
  logic [CNT_W-1:0] filt_limit;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(hpd_async_i), .q_o(hpd_sync)
  );

  hpd_debounce #(.EXP_W(EXP_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_deb (
    .clk(clk), .rst(rst), .sync_i(hpd_sync), .exp_i(filt_exp),
    .limit_i(filt_limit), .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  hpd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .rise_i(rise),
    .fall_i(fall), .core_irq_i(core_irq_i), .level_i(level),
    .exp_o(filt_exp), .limit_o(filt_limit), .irq_o(irq_o)
  );
endmodule

// File: tb/hpd_irq_unit_tb.sv
module hpd_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hpd = 1'b0;
  logic        core = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hpd_irq_unit u_dut (
    .clk(clk), .rst(rst), .hpd_async_i(hpd), .core_irq_i(core),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd(3'd0, v); chk("R1 filter", v, 32'h0000A0A0);
    rd(3'd1, v); chk("R1 status", v, 32'd0);
    rd(3'd3, v); chk("R1 enable", v, 32'd0);
    rd(3'd4, v); chk("R1 level", v, 32'd0);
  endtask

  task automatic t_filter_rw;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_3004);
    rd(3'd0, v); chk("R9 filter upper bits", v, 32'h0000_3004);
    rd(3'd2, v); chk("R9 clear reads zero", v, 32'd0);
    wr(3'd0, 32'h0000_0004);   // EXP=0, LIMIT=4
  endtask

  task automatic t_glitch;
    logic [31:0] v;
    hpd = 1'b1; wait_cyc(2); hpd = 1'b0; wait_cyc(12);
    rd(3'd4, v); chk("R2 glitch level", v, 32'd0);
    rd(3'd1, v); chk("R4 glitch no event", v, 32'd0);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    hpd = 1'b1; wait_cyc(20);
    rd(3'd4, v); chk("R2 held level", v, 32'd1);
    rd(3'd1, v); chk("R4 rise bit1", v, 32'd2);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wait_cyc(3);
    chk("R7 zero enable blocks", {31'b0, irq}, 32'd0);
    wr(3'd3, 32'd4); wait_cyc(3);
    chk("R7 other enable blocks", {31'b0, irq}, 32'd0);
    wr(3'd3, 32'd2); wait_cyc(3);
    chk("R7 matching enable", {31'b0, irq}, 32'd1);
    wr(3'd1, 32'd0);
    rd(3'd1, v); chk("R8 status write ignored", v, 32'd2);
    wr(3'd2, 32'd2); wait_cyc(3);
    rd(3'd1, v); chk("R6 clear exact", v, 32'd0);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(3'd0, 32'h0000_2004);  // EXP=2, LIMIT=4: about 16 cycles
    hpd = 1'b0; wait_cyc(8); hpd = 1'b1; wait_cyc(30);
    rd(3'd4, v); chk("R3 short pulse rejected", v, 32'd1);
    rd(3'd1, v); chk("R3 no fall event", v, 32'd0);
    hpd = 1'b0; wait_cyc(6);
    rd(3'd4, v); chk("R3 still high mid window", v, 32'd1);
    wait_cyc(40);
    rd(3'd4, v); chk("R2 level low", v, 32'd0);
    rd(3'd1, v); chk("R4 fall bit2", v, 32'd4);
    wr(3'd2, 32'd4);
  endtask

  task automatic t_core;
    logic [31:0] v;
    core = 1'b1; wait_cyc(2);
    wr(3'd2, 32'd1);
    rd(3'd1, v); chk("R6 set wins over clear", v, 32'd1);
    core = 1'b0; wait_cyc(2);
    rd(3'd1, v); chk("R5 core sticky", v, 32'd1);
    wr(3'd3, 32'd1); wait_cyc(3);
    chk("R5 core irq out", {31'b0, irq}, 32'd1);
    wr(3'd2, 32'd7);
    rd(3'd1, v); chk("R6 cleared", v, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_filter_rw();
    t_glitch();
    t_rise();
    t_enable();
    t_prescale();
    t_core();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule